// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

This block lets one processor hand a fixed message of eight 32-bit words to another processor and signal it with an interrupt. Software reaches it through a plain 32-bit register port. The port has a write strobe and a read strobe, and read data comes back one cycle after the read strobe. The port has no back-pressure. A strobe is accepted in every cycle, and a read answer is valid in the single cycle in which `rd_valid` is high.

The block holds `NCH` channels (up to 32). Each channel has its own 64-byte window at `channel * 0x40`. A sender claims a channel by writing a one-hot source vector, fills the message words, programs destination vectors and a mask, then writes the send register. The receiver sees the unmasked destination vectors on `dst_irq` and clears them. In automatic-acknowledge mode, the send also raises the sender's own vector on `ack_irq`. The sender clears that interrupt to get the channel back. A global key register at 0xA00 guards every other write.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the key register at 0xA00 reads 1. Every channel mode register reads 0x10, meaning only the idle flag is set. Every interrupt mask reads 0xFFFFFFFF, and both interrupt outputs are zero.
- R2: While locked, any write other than to 0xA00 has no effect. Writing 0x1ACCE551 to 0xA00 unlocks the block, and the key register then reads 0. Writing any other value to 0xA00 locks the block again.
- R3: A write of a one-hot value to the source register (offset 0x00) of an idle channel stores it and moves the channel to ready, so mode bit 5 is set and bit 4 is clear. A non-one-hot value is ignored. A non-zero write to a channel that is not idle is also ignored.
- R4: Writing zero to the source register of a ready channel clears it and returns the channel to idle.
- R5: The message words sit at offsets 0x20 to 0x3C and read back what was written. They accept writes only while the channel is ready.
- R6: A write to the send register (0x1C) whose value equals the stored source vector ORs `dst & ~mask` into the pending destination bits. The destination register is at 0x04 and the mask at 0x14, and a set mask bit blocks that vector. A send with any other value, or a send while the channel is not ready, is ignored.
- R7: With mode bit 0 set (automatic acknowledge), a send moves the channel to acknowledged, so mode bit 7 is set, and raises the source vector on `ack_irq`. Writing that source bit to the interrupt-clear register (0x18) drops it and returns the channel to ready.
- R8: With mode bit 0 clear, a send makes the channel busy, so mode bits 4, 5 and 7 are all clear. A write to destination-clear that leaves no pending bit returns the channel to ready.
- R9: Destination status (0x0C) reads the pending destination bits. Writing ones to destination-clear (0x08) clears the matching pending bits.
- R10: `dst_irq` and `ack_irq` are the bitwise OR of the pending destination bits and the pending acknowledge bits across all channels.
- R11: A read of an unimplemented location returns 0. This covers offsets 0x08, 0x18 and 0x1C, windows at or beyond `NCH`, and any global address other than 0xA00. Every read raises `rd_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read answer valid, one cycle after rd_en |
| dst_irq | output | 32 | Pending destination interrupt vectors |
| ack_irq | output | 32 | Pending acknowledge interrupt vectors |

## Verification
Random rounds pick a channel, a one-hot source, destination and mask vectors, a mode and message words. Each round checks that the interrupt outputs equal `dst & ~mask`, which tells a correct mask polarity apart from an inverted or ignored one. It also checks that `ack_irq` follows the mode bit. Directed cases cover the following:
- a wrong key and writes made while locked;
- a non-one-hot claim and a second claim on an owned channel;
- a send with a foreign source and message writes outside the ready state;
- two channels pending at once, so the OR across channels is distinguished from a single selected channel;
- out-of-window reads.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {CH_IDLE, CH_READY, CH_BUSY, CH_ACKED} ch_state_e;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned WIN_SH   = 6;
  localparam int unsigned MSG_W    = 8;
  localparam logic [3:0] R_SRC  = 4'd0;
  localparam logic [3:0] R_DST  = 4'd1;
  localparam logic [3:0] R_DCLR = 4'd2;
  localparam logic [3:0] R_DSTA = 4'd3;
  localparam logic [3:0] R_MODE = 4'd4;
  localparam logic [3:0] R_MASK = 4'd5;
  localparam logic [3:0] R_ICLR = 4'd6;
  localparam logic [3:0] R_SEND = 4'd7;
  localparam logic [ADDR_W-1:0] KEY_ADDR = 12'hA00;
  localparam logic [31:0] KEY_VAL = 32'h1ACC_E551;
endpackage

// File: rtl/mbox_lock.sv
module mbox_lock
  import mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_wdata,
  output logic        locked
);
  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b1;
    else if (key_we) locked <= (key_wdata != KEY_VAL);
  end

  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_wdata == KEY_VAL) |=> !locked);
  // R2
  bad_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_wdata != KEY_VAL) |=> locked);
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int unsigned NVEC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [3:0]      woff,
  input  logic [31:0]     wdata,
  input  logic [3:0]      roff,
  output logic [31:0]     rd,
  output logic [NVEC-1:0] dpend,
  output logic [NVEC-1:0] apend,
  output ch_state_e       st
);
  logic [NVEC-1:0] src, dst, mask;
  logic            auto_ack;
  logic [31:0]     msg [MSG_W];
  logic [NVEC-1:0] wv, dclr_next;
  logic            wv_onehot;

  assign wv        = wdata[NVEC-1:0];
  assign wv_onehot = (wdata != 32'd0) && ((wdata & (wdata - 32'd1)) == 32'd0);
  assign dclr_next = dpend & ~wv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= CH_IDLE; src <= '0; dst <= '0; mask <= '1;
      auto_ack <= 1'b0; dpend <= '0; apend <= '0;
      for (int i = 0; i < MSG_W; i++) msg[i] <= '0;
    end else if (we) begin
      case (woff)
        R_SRC: begin
          if (st == CH_IDLE && wv_onehot) begin
            src <= wv; st <= CH_READY;
          end else if (st == CH_READY && wdata == 32'd0) begin
            src <= '0; st <= CH_IDLE;
          end
        end
        R_DST:  dst <= wv;
        R_DCLR: begin
          dpend <= dclr_next;
          if (st == CH_BUSY && dclr_next == '0) st <= CH_READY;
        end
        R_MODE: auto_ack <= wdata[0];
        R_MASK: mask <= wv;
        R_ICLR: begin
          apend <= apend & ~wv;
          if (st == CH_ACKED && (wv & src) != '0) st <= CH_READY;
        end
        R_SEND: begin
          if (st == CH_READY && wdata == 32'(src)) begin
            dpend <= dpend | (dst & ~mask);
            if (auto_ack) begin
              apend <= apend | src; st <= CH_ACKED;
            end else st <= CH_BUSY;
          end
        end
        R_DSTA: ;
        default: if (st == CH_READY) msg[woff[2:0]] <= wdata;
      endcase
    end
  end

  always_comb begin
    case (roff)
      R_SRC:  rd = 32'(src);
      R_DST:  rd = 32'(dst);
      R_DSTA: rd = 32'(dpend);
      R_MODE: rd = {24'd0, st == CH_ACKED, 1'b0, st == CH_READY, st == CH_IDLE, 3'd0, auto_ack};
      R_MASK: rd = 32'(mask);
      R_DCLR, R_ICLR, R_SEND: rd = 32'd0;
      default: rd = msg[roff[2:0]];
    endcase
  end

  // R3
  claim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == CH_IDLE && st == CH_READY) |-> $onehot(src));
  // R4
  idle_no_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_IDLE) |-> (src == '0));
  // R7
  acked_has_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_ACKED) |-> ((apend & src) != '0));
  // R6
  pend_only_on_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && woff == R_SEND) |=> ((dpend & ~$past(dpend)) == '0));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned NCH  = 4,
  parameter int unsigned NVEC = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rd_valid,
  output logic [31:0] dst_irq,
  output logic [31:0] ack_irq
);
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned WIN_END = NCH << WIN_SH;

  logic            locked, in_win, is_key;
  logic [CHW-1:0]  ch_idx;
  logic [3:0]      off;
  logic [31:0]     ch_rd [NCH];
  logic [NVEC-1:0] ch_dp [NCH];
  logic [NVEC-1:0] ch_ap [NCH];
  ch_state_e       ch_st [NCH];
  logic [2*NCH-1:0] st_flat;
  logic [NVEC-1:0] dst_or, ack_or;

  assign in_win = 32'(addr) < WIN_END;
  assign is_key = addr == KEY_ADDR;
  assign ch_idx = addr[WIN_SH +: CHW];
  assign off    = addr[5:2];

  mbox_lock u_lock (
    .clk(clk), .rst_n(rst_n), .key_we(wr_en && is_key),
    .key_wdata(wdata), .locked(locked)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mbox_chan #(.NVEC(NVEC)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && !locked && in_win && ch_idx == CHW'(g)),
      .woff(off), .wdata(wdata), .roff(off), .rd(ch_rd[g]),
      .dpend(ch_dp[g]), .apend(ch_ap[g]), .st(ch_st[g])
    );
    assign st_flat[2*g +: 2] = ch_st[g];
  end

  always_comb begin
    dst_or = '0;
    ack_or = '0;
    for (int i = 0; i < NCH; i++) begin
      dst_or |= ch_dp[i];
      ack_or |= ch_ap[i];
    end
  end
  assign dst_irq = 32'(dst_or);
  assign ack_irq = 32'(ack_or);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (is_key)      rdata <= {31'd0, locked};
        else if (in_win) rdata <= ch_rd[ch_idx];
        else             rdata <= '0;
      end
    end
  end

  // R2
  locked_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(wr_en && is_key)) |=> $stable(st_flat));
  // R11
  read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R10
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_dp[0] & ~dst_or) == '0) && ((ch_ap[0] & ~ack_or) == '0));
endmodule

// File: tb/tb_mbox_ctrl.sv
module tb_mbox_ctrl;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata, dst_irq, ack_irq;
  logic rd_valid;
  int n_chk = 0, n_fail = 0;
  logic done = 0;

  always #2 clk = ~clk;

  mbox_ctrl #(.NCH(NCH), .NVEC(32)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .dst_irq(dst_irq), .ack_irq(ack_irq)
  );

  function automatic logic [11:0] ra(int ch, int off);
    return 12'(ch * 64 + off);
  endfunction
  function automatic logic [31:0] exp_pend(logic [31:0] d, logic [31:0] m);
    return d & ~m;
  endfunction
  function automatic logic [31:0] exp_mode(int st, logic au);
    // st: 0 idle, 1 ready, 2 busy, 3 acked
    return {24'd0, st == 3, 1'b0, st == 1, st == 0, 3'd0, au};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
    if (rd_valid !== 1'b1) begin n_fail++; $display("FAIL R11 rd_valid got=%b exp=1", rd_valid); end
    n_chk++;
  endtask

  task automatic rchk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, sbit, d, m, w[8];
    logic au;
    int c, c2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rchk("R1 lock", 12'hA00, 32'd1);
    for (int i = 0; i < NCH; i++) begin
      rchk("R1 mode", ra(i, 'h10), exp_mode(0, 0));
      rchk("R1 mask", ra(i, 'h14), 32'hFFFF_FFFF);
    end
    chk("R1 dst_irq", dst_irq, 0);
    chk("R1 ack_irq", ack_irq, 0);
    // R2 locked writes ignored
    wr(ra(0, 'h00), 32'h1);
    wr(ra(0, 'h04), 32'h55);
    rchk("R2 locked claim", ra(0, 'h10), exp_mode(0, 0));
    wr(12'hA00, 32'h1ACC_E550);
    rchk("R2 wrong key", 12'hA00, 32'd1);
    wr(12'hA00, 32'h1ACC_E551);
    rchk("R2 unlocked", 12'hA00, 32'd0);
    rchk("R2 dst kept", ra(0, 'h04), 32'd0);
    wr(12'hA00, 32'h0);
    wr(ra(1, 'h04), 32'hAA);
    wr(12'hA00, 32'h1ACC_E551);
    rchk("R2 relock", ra(1, 'h04), 32'd0);
    // R3 claim rules
    wr(ra(0, 'h00), 32'h3);
    rchk("R3 non-onehot", ra(0, 'h10), exp_mode(0, 0));
    wr(ra(0, 'h00), 32'h4);
    rchk("R3 src", ra(0, 'h00), 32'h4);
    rchk("R3 ready", ra(0, 'h10), exp_mode(1, 0));
    wr(ra(0, 'h00), 32'h8);
    rchk("R3 reclaim ignored", ra(0, 'h00), 32'h4);
    // R5 data outside ready ignored (channel 1 idle)
    wr(ra(1, 'h20), 32'hDEAD);
    rchk("R5 idle write", ra(1, 'h20), 32'd0);
    // R6 foreign send ignored
    wr(ra(0, 'h04), 32'h30);
    wr(ra(0, 'h14), 32'h0);
    wr(ra(0, 'h1C), 32'h8);
    chk("R6 foreign send", dst_irq, 0);
    rchk("R6 still ready", ra(0, 'h10), exp_mode(1, 0));
    // R8 manual mode send -> busy, dclr partial, then full
    wr(ra(0, 'h1C), 32'h4);
    chk("R8 dst_irq", dst_irq, 32'h30);
    chk("R8 no ack", ack_irq, 0);
    rchk("R8 busy", ra(0, 'h10), exp_mode(2, 0));
    wr(ra(0, 'h20), 32'h77);
    rchk("R5 busy write", ra(0, 'h20), 32'd0);
    // R10 second channel pending at same time
    wr(ra(2, 'h00), 32'h1);
    wr(ra(2, 'h04), 32'h0300);
    wr(ra(2, 'h14), 32'h0100);
    wr(ra(2, 'h1C), 32'h1);
    chk("R10 or", dst_irq, 32'h0230);
    wr(ra(0, 'h08), 32'h10);
    rchk("R9 dstat", ra(0, 'h0C), 32'h20);
    rchk("R8 still busy", ra(0, 'h10), exp_mode(2, 0));
    wr(ra(0, 'h08), 32'h20);
    rchk("R8 back ready", ra(0, 'h10), exp_mode(1, 0));
    chk("R10 other ch", dst_irq, 32'h0200);
    wr(ra(2, 'h08), 32'hFFFF_FFFF);
    // R4 release
    wr(ra(0, 'h00), 32'h0);
    rchk("R4 idle", ra(0, 'h10), exp_mode(0, 0));
    rchk("R4 src zero", ra(0, 'h00), 32'd0);
    // R11 unimplemented
    rchk("R11 dclr", ra(2, 'h08), 0);
    rchk("R11 iclr", ra(2, 'h18), 0);
    rchk("R11 send", ra(2, 'h1C), 0);
    rchk("R11 beyond", ra(NCH, 'h04), 0);
    rchk("R11 global", 12'hA04, 0);
    wr(ra(2, 'h00), 32'h0);
    // Random rounds: R5 R6 R7 R8
    for (int it = 0; it < 40; it++) begin
      c = $urandom_range(NCH - 1);
      sbit = 32'h1 << $urandom_range(31);
      d = $urandom; m = $urandom;
      au = $urandom_range(1);
      for (int k = 0; k < 8; k++) w[k] = $urandom;
      wr(ra(c, 'h00), sbit);
      rchk("R3 rnd src", ra(c, 'h00), sbit);
      wr(ra(c, 'h04), d);
      wr(ra(c, 'h14), m);
      wr(ra(c, 'h10), {31'd0, au});
      for (int k = 0; k < 8; k++) wr(ra(c, 'h20 + 4 * k), w[k]);
      for (int k = 0; k < 8; k++) rchk("R5 rnd data", ra(c, 'h20 + 4 * k), w[k]);
      wr(ra(c, 'h1C), sbit);
      chk("R6 rnd dst_irq", dst_irq, exp_pend(d, m));
      chk("R7 rnd ack_irq", ack_irq, au ? sbit : 32'd0);
      rchk("R7 rnd mode", ra(c, 'h10), exp_mode(au ? 3 : 2, au));
      rchk("R9 rnd dstat", ra(c, 'h0C), exp_pend(d, m));
      if (au) begin
        wr(ra(c, 'h18), sbit);
        chk("R7 ack drop", ack_irq, 0);
        rchk("R7 ready", ra(c, 'h10), exp_mode(1, au));
        wr(ra(c, 'h08), 32'hFFFF_FFFF);
      end else begin
        wr(ra(c, 'h08), 32'hFFFF_FFFF);
        rchk("R8 ready", ra(c, 'h10), exp_mode(1, au));
      end
      chk("R9 cleared", dst_irq, 0);
      wr(ra(c, 'h00), 32'h0);
      rchk("R4 rnd idle", ra(c, 'h10), exp_mode(0, au));
      c2 = c;
    end
    finish_run();
  end
endmodule